// File: doc/BRIEF.md
# Byte-Stuffed Frame Receiver with CRC-8 Check

This block sits behind a serial byte receiver and turns its raw byte stream into checked command frames. It finds frame boundaries from reserved flag bytes, removes escaping, and keeps a running CRC-8 over the recovered bytes. It also notes whether the command byte announces a device address. A frame is released only after its trailing CRC has been verified. Failing frames leave no trace downstream apart from a status pulse.

Good frames come out one byte per handshake on a valid/ready port: the full command byte first, then the address byte if there is one, then the payload. The CRC is stripped. Flags mark the first and last byte of each frame. Every frame that reaches its end flag produces one status pulse carrying a pass/fail bit, the 7-bit command identifier and the resolved device address. Higher logic uses that pulse to send its acknowledge or refusal. Recovered bytes wait in a circular store until the verdict is known. A frame that does not fit in the free space is refused.

Top module: `frame_rx`

## Requirements
- R1: Byte 0x02 opens a frame at any time. Bytes that arrive while no frame is open, including 0x03 and 0x1B, produce no output byte and no status pulse.
- R2: Byte 0x03 inside an open frame closes it. Exactly one status pulse (`st_valid` high for one cycle) follows in the next clock cycle.
- R3: Inside a frame, byte 0x1B is dropped and the byte after it is taken as data in bitwise-inverted form. For example, 0x1B 0xFD yields data 0x02.
- R4: An escaped byte whose inverse is not one of 0x02, 0x03 or 0x1B makes the frame fail.
- R5: The last recovered byte of a frame is a CRC-8 over all earlier recovered bytes. It uses generator 0x1D, start value 0x00, most significant bit first, with no reflection and no final inversion. A mismatch makes the frame fail.
- R6: When bit 7 of the command byte is 1, the second recovered byte is the device address and is reported on `st_addr`. Otherwise `st_addr` reports 0. `st_cmd` carries bits 6:0 of the command byte.
- R7: A frame fails in any of these cases: it closes with fewer than two recovered bytes; it has bit 7 of the command set and fewer than three recovered bytes; or its 0x03 directly follows an escape byte.
- R8: A 0x02 arriving inside an open frame discards the partial frame. No status pulse and no output are produced for the discarded part.
- R9: Only passing frames are released. Their bytes come out in arrival order without the CRC. `out_first` is set on the command byte and `out_last` on the final non-CRC byte. If the command byte is the only non-CRC byte, both flags are set on it.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_first` stay unchanged.
- R11: A frame whose recovered bytes do not fit in the free space of the store fails and releases nothing. The store holds DEPTH-1 bytes, minus any bytes of earlier frames not yet read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A raw byte is present this cycle |
| in_byte | input | 8 | Raw byte from the serial receiver |
| out_valid | output | 1 | A released frame byte is available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Released frame byte |
| out_first | output | 1 | Byte is the command byte of its frame |
| out_last | output | 1 | Byte is the final non-CRC byte of its frame |
| st_valid | output | 1 | One-cycle frame status pulse |
| st_ok | output | 1 | Frame passed all checks |
| st_cmd | output | 7 | Command identifier, bits 6:0 of the command byte |
| st_addr | output | 8 | Resolved device address |

## Verification
The assertions assume that `in_valid` and `in_byte` are known whenever reset is released, and that the downstream side does not depend on `out_ready` being asserted at any particular time. The hold property assumes that the store never overwrites unread bytes. The stimulus drives raw bytes only on falling clock edges, with idle gaps between frames, and leaves `out_ready` under test control to create stalls. The bench also sends deliberately malformed streams: stray flags, restarts, bad escapes and over-long frames. These stay within the assumptions because every malformed case still leaves the inputs known on every cycle.

// File: rtl/frx_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the CRC-8 step for the frame receiver.
// Assumes MSB-first CRC with no reflection and no final inversion.
package frx_pkg;
    localparam logic [7:0] FLAG_OPEN  = 8'h02;
    localparam logic [7:0] FLAG_CLOSE = 8'h03;
    localparam logic [7:0] FLAG_ESC   = 8'h1B;
    localparam logic [7:0] CRC_GEN    = 8'h1D;

    typedef struct packed {
        logic       first;
        logic [7:0] data;
    } slot_t;

    // One byte of CRC-8 update.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
        logic [7:0] c;
        c = crc ^ b;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ CRC_GEN) : (c << 1);
        end
        return c;
    endfunction

    // True for the three reserved flag values.
    function automatic logic is_flag(input logic [7:0] b);
        return (b == FLAG_OPEN) || (b == FLAG_CLOSE) || (b == FLAG_ESC);
    endfunction
endpackage

// File: rtl/frx_unstuff.sv
`timescale 1ns/1ps
// Frame delimiting and escape removal.
// Emits one-cycle events for open, close and each recovered byte.
// Assumes in_byte is meaningful only when in_valid is high.
module frx_unstuff
    import frx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       u_open,
    output logic       u_close,
    output logic       u_dv,
    output logic [7:0] u_data,
    output logic       u_code_err,
    output logic       u_close_in_esc
);
    logic in_frame;
    logic esc_pend;
    logic esc_take;

    // Classify the current raw byte against framing state.
    always_comb begin
        u_open         = in_valid && (in_byte == FLAG_OPEN);
        u_close        = in_valid && in_frame && (in_byte == FLAG_CLOSE);
        esc_take       = in_valid && in_frame && !esc_pend && (in_byte == FLAG_ESC);
        u_dv           = in_valid && in_frame && !u_open && (in_byte != FLAG_CLOSE) && !esc_take;
        u_data         = esc_pend ? ~in_byte : in_byte;
        u_code_err     = u_dv && esc_pend && !is_flag(~in_byte);
        u_close_in_esc = u_close && esc_pend;
    end

    // Track whether a frame is open and whether an escape is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            esc_pend <= 1'b0;
        end else if (u_open) begin
            in_frame <= 1'b1;
            esc_pend <= 1'b0;
        end else if (u_close) begin
            in_frame <= 1'b0;
            esc_pend <= 1'b0;
        end else if (esc_take) begin
            esc_pend <= 1'b1;
        end else if (u_dv) begin
            esc_pend <= 1'b0;
        end
    end

    a_r1_open_starts_clean: assert property (@(posedge clk) disable iff (!rst_n)
        u_open |=> (in_frame && !esc_pend));
    a_r3_escape_arms: assert property (@(posedge clk) disable iff (!rst_n)
        esc_take |=> esc_pend);
    a_r1_idle_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> !u_dv && !u_close);
endmodule

// File: rtl/frx_check.sv
`timescale 1ns/1ps
// Per-frame checking: CRC, length, escape validity, store overflow.
// Captures command and address, drives store writes and the verdict.
// Assumes open, close and data events are mutually exclusive.
module frx_check
    import frx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       u_open,
    input  logic       u_close,
    input  logic       u_dv,
    input  logic [7:0] u_data,
    input  logic       u_code_err,
    input  logic       u_close_in_esc,
    input  logic       store_full,
    output logic       wr_en,
    output slot_t      wr_slot,
    output logic       commit,
    output logic       discard,
    output logic       st_valid,
    output logic       st_ok,
    output logic [6:0] st_cmd,
    output logic [7:0] st_addr
);
    logic [7:0] crc_q;
    logic [1:0] cnt_q;
    logic       err_q;
    logic [7:0] cmd_q;
    logic [7:0] addr_q;
    logic       short_f;
    logic       pass;

    // Store write request and end-of-frame verdict.
    always_comb begin
        wr_en         = u_dv && !store_full;
        wr_slot.first = (cnt_q == 2'd0);
        wr_slot.data  = u_data;
        short_f       = (cnt_q < 2'd2) || (cmd_q[7] && (cnt_q < 2'd3));
        pass          = !err_q && !u_close_in_esc && !short_f && (crc_q == 8'h00);
        commit        = u_close && pass;
        discard       = u_open || (u_close && !pass);
    end

    // Accumulate CRC, length, error and header fields per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || u_open) begin
            crc_q  <= 8'h00;
            cnt_q  <= 2'd0;
            err_q  <= 1'b0;
            cmd_q  <= 8'h00;
            addr_q <= 8'h00;
        end else if (u_dv) begin
            crc_q <= crc8_step(crc_q, u_data);
            if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
            if (cnt_q == 2'd0) cmd_q <= u_data;
            if (cnt_q == 2'd1) addr_q <= u_data;
            err_q <= err_q || u_code_err || store_full;
        end
    end

    // Register the status pulse one cycle after the close flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_valid <= 1'b0;
            st_ok    <= 1'b0;
            st_cmd   <= 7'd0;
            st_addr  <= 8'd0;
        end else begin
            st_valid <= u_close;
            if (u_close) begin
                st_ok   <= pass;
                st_cmd  <= cmd_q[6:0];
                st_addr <= cmd_q[7] ? addr_q : 8'd0;
            end
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid);
    a_r6_default_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !cmd_q[7]) |-> (st_addr == 8'd0));
    a_r7_pass_needs_length: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ok) |-> (cnt_q >= 2'd2));
endmodule

// File: rtl/frx_store.sv
`timescale 1ns/1ps
// Circular byte store with speculative write and commit/discard.
// Bytes become readable only once their frame is committed; the CRC
// slot is dropped at commit. DEPTH must be a power of two.
module frx_store
    import frx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  slot_t      wr_slot,
    input  logic       commit,
    input  logic       discard,
    output logic       full,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_first,
    output logic       rd_last
);
    localparam int AW = $clog2(DEPTH);

    slot_t         mem [DEPTH];
    logic [AW-1:0] wptr, cptr, rptr, rnext;

    // Occupancy and read-side view.
    always_comb begin
        rnext    = rptr + 1'b1;
        full     = ((wptr + 1'b1) == rptr);
        rd_valid = (rptr != cptr);
        rd_data  = mem[rptr].data;
        rd_first = mem[rptr].first;
        rd_last  = (rnext == cptr) || mem[rnext].first;
    end

    // Write recovered bytes at the speculative pointer.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_slot;
    end

    // Move write, commit and read pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            cptr <= '0;
            rptr <= '0;
        end else begin
            if (discard) begin
                wptr <= cptr;
            end else if (commit) begin
                wptr <= wptr - 1'b1;
                cptr <= wptr - 1'b1;
            end else if (wr_en) begin
                wptr <= wptr + 1'b1;
            end
            if (rd_valid && rd_ready) rptr <= rptr + 1'b1;
        end
    end

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_first)));
    a_r11_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en);
endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
// Top of the byte-stuffed frame receiver: unstuffing, checking and a
// commit-on-pass store feeding a valid/ready output.
// Assumes at most one raw byte per cycle and no input back-pressure.
module frame_rx
    import frx_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_first,
    output logic       out_last,
    output logic       st_valid,
    output logic       st_ok,
    output logic [6:0] st_cmd,
    output logic [7:0] st_addr
);
    logic       u_open, u_close, u_dv, u_code_err, u_close_in_esc;
    logic [7:0] u_data;
    logic       wr_en, commit, discard, store_full;
    slot_t      wr_slot;

    frx_unstuff u_unstuff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .u_open(u_open), .u_close(u_close), .u_dv(u_dv), .u_data(u_data),
        .u_code_err(u_code_err), .u_close_in_esc(u_close_in_esc)
    );

    frx_check u_check (
        .clk(clk), .rst_n(rst_n), .u_open(u_open), .u_close(u_close),
        .u_dv(u_dv), .u_data(u_data), .u_code_err(u_code_err),
        .u_close_in_esc(u_close_in_esc), .store_full(store_full),
        .wr_en(wr_en), .wr_slot(wr_slot), .commit(commit), .discard(discard),
        .st_valid(st_valid), .st_ok(st_ok), .st_cmd(st_cmd), .st_addr(st_addr)
    );

    frx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .commit(commit), .discard(discard), .full(store_full),
        .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(out_data),
        .rd_first(out_first), .rd_last(out_last)
    );

    a_r9_release_only_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (st_valid && st_ok));
endmodule

// File: tb/tb_frame_rx.sv
`timescale 1ns/1ps
module tb_frame_rx;
    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_ready = 1'b1;
    logic       out_valid, out_first, out_last, st_valid, st_ok;
    logic [7:0] out_data, st_addr;
    logic [6:0] st_cmd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [9:0]  got_q[$];   // {first,last,data}
    logic [15:0] st_q[$];    // {ok,cmd,addr}

    frame_rx #(.DEPTH(32)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .st_valid(st_valid),
        .st_ok(st_ok), .st_cmd(st_cmd), .st_addr(st_addr)
    );

    always #2.5 clk = ~clk;

    // Monitor samples registered outputs on the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) got_q.push_back({out_first, out_last, out_data});
        if (rst_n && st_valid) st_q.push_back({st_ok, st_cmd, st_addr});
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] crc8(input bq_t b);
        logic [7:0] c = 8'h00;
        foreach (b[i]) begin
            c = c ^ b[i];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
        end
        return c;
    endfunction

    task automatic send_raw(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
    endtask

    task automatic send_stuffed(input logic [7:0] b);
        if (b == 8'h02 || b == 8'h03 || b == 8'h1B) begin
            send_raw(8'h1B);
            send_raw(~b);
        end else begin
            send_raw(b);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic send_frame(input bq_t body, input logic [7:0] crc_flip);
        logic [7:0] c;
        c = crc8(body) ^ crc_flip;
        send_raw(8'h02);
        foreach (body[i]) send_stuffed(body[i]);
        send_stuffed(c);
        send_raw(8'h03);
        idle(1);
    endtask

    task automatic clear();
        got_q.delete();
        st_q.delete();
    endtask

    task automatic expect_status(input string req, input bit ok, input logic [6:0] cmd,
                                 input logic [7:0] addr, input bit check_fields);
        chk(st_q.size() == 1, req, st_q.size(), 1);
        if (st_q.size() == 1) begin
            chk(st_q[0][15] == ok, req, st_q[0][15], ok);
            if (check_fields) begin
                chk(st_q[0][14:8] == cmd, req, st_q[0][14:8], cmd);
                chk(st_q[0][7:0] == addr, req, st_q[0][7:0], addr);
            end
        end
    endtask

    task automatic expect_out(input string req, input bq_t exp);
        logic [9:0] e;
        chk(got_q.size() == exp.size(), req, got_q.size(), exp.size());
        if (got_q.size() == exp.size()) begin
            foreach (exp[i]) begin
                e = {(i == 0), (i == exp.size() - 1), exp[i]};
                chk(got_q[i] == e, req, got_q[i], e);
            end
        end
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        chk(st_valid == 1'b0, "R2 reset st_valid", st_valid, 0);
    endtask

    task automatic t_plain();
        clear();
        send_frame('{8'h11, 8'hA0, 8'h55}, 8'h00);
        idle(10);
        expect_status("R2 R5 R6 plain", 1'b1, 7'h11, 8'h00, 1'b1);
        expect_out("R9 plain", '{8'h11, 8'hA0, 8'h55});
    endtask

    task automatic t_addressed();
        clear();
        send_frame('{8'h85, 8'h07, 8'h02, 8'h1B, 8'h03}, 8'h00);
        idle(10);
        expect_status("R6 addressed", 1'b1, 7'h05, 8'h07, 1'b1);
        expect_out("R3 escapes recovered", '{8'h85, 8'h07, 8'h02, 8'h1B, 8'h03});
    endtask

    task automatic t_cmd_only();
        clear();
        send_frame('{8'h3C}, 8'h00);
        idle(8);
        expect_status("R5 cmd only", 1'b1, 7'h3C, 8'h00, 1'b1);
        expect_out("R9 single byte first+last", '{8'h3C});
    endtask

    task automatic t_bad_crc();
        clear();
        send_frame('{8'h22, 8'h10, 8'h20}, 8'h01);
        idle(10);
        expect_status("R5 bad crc", 1'b0, 7'h22, 8'h00, 1'b0);
        chk(got_q.size() == 0, "R9 bad crc nothing out", got_q.size(), 0);
    endtask

    task automatic t_outside();
        clear();
        send_raw(8'h55); send_raw(8'h03); send_raw(8'h1B); send_raw(8'hAA);
        idle(6);
        chk(st_q.size() == 0, "R1 stray bytes no status", st_q.size(), 0);
        chk(got_q.size() == 0, "R1 stray bytes no output", got_q.size(), 0);
        send_frame('{8'h20, 8'h31}, 8'h00);
        idle(8);
        expect_status("R1 frame after stray", 1'b1, 7'h20, 8'h00, 1'b1);
        expect_out("R1 output after stray", '{8'h20, 8'h31});
    endtask

    task automatic t_restart();
        clear();
        send_raw(8'h02); send_raw(8'h12); send_raw(8'h34);
        send_frame('{8'h13, 8'h99}, 8'h00);
        idle(8);
        expect_status("R8 restart", 1'b1, 7'h13, 8'h00, 1'b1);
        expect_out("R8 only second frame", '{8'h13, 8'h99});
    endtask

    task automatic t_bad_escape();
        clear();
        send_raw(8'h02); send_raw(8'h21); send_raw(8'h1B); send_raw(8'h40);
        send_stuffed(crc8('{8'h21, 8'hBF}));
        send_raw(8'h03);
        idle(8);
        expect_status("R4 bad escape", 1'b0, 7'h21, 8'h00, 1'b0);
        chk(got_q.size() == 0, "R4 bad escape nothing out", got_q.size(), 0);
    endtask

    task automatic t_short();
        clear();
        send_raw(8'h02); send_raw(8'h03); idle(4);
        expect_status("R7 empty frame", 1'b0, 7'h0, 8'h0, 1'b0);
        clear();
        send_raw(8'h02); send_raw(8'h44); send_raw(8'h03); idle(4);
        expect_status("R7 one byte frame", 1'b0, 7'h0, 8'h0, 1'b0);
        clear();
        send_frame('{8'h80}, 8'h00); idle(4);
        expect_status("R7 missing address", 1'b0, 7'h0, 8'h0, 1'b0);
        clear();
        send_raw(8'h02); send_raw(8'h10); send_stuffed(crc8('{8'h10}));
        send_raw(8'h1B); send_raw(8'h03); idle(4);
        expect_status("R7 close after escape", 1'b0, 7'h0, 8'h0, 1'b0);
        chk(got_q.size() == 0, "R7 short frames nothing out", got_q.size(), 0);
    endtask

    task automatic t_backpressure();
        bq_t both;
        clear();
        out_ready = 1'b0;
        send_frame('{8'h81, 8'h05, 8'hEE}, 8'h00);
        send_frame('{8'h0F}, 8'h00);
        idle(4);
        chk(st_q.size() == 2, "R2 two statuses", st_q.size(), 2);
        chk(out_valid && out_data == 8'h81 && out_first, "R10 head byte", out_data, 8'h81);
        idle(3);
        chk(out_valid && out_data == 8'h81 && out_first, "R10 held while stalled", out_data, 8'h81);
        @(negedge clk);
        out_ready = 1'b1;
        idle(10);
        chk(got_q.size() == 4, "R9 two frames drained", got_q.size(), 4);
        if (got_q.size() == 4) begin
            chk(got_q[0] == {2'b10, 8'h81}, "R9 frame A first", got_q[0], {2'b10, 8'h81});
            chk(got_q[2] == {2'b01, 8'hEE}, "R9 frame A last", got_q[2], {2'b01, 8'hEE});
            chk(got_q[3] == {2'b11, 8'h0F}, "R9 frame B single", got_q[3], {2'b11, 8'h0F});
        end
        both = '{};
    endtask

    task automatic t_overflow();
        bq_t body;
        clear();
        out_ready = 1'b0;
        body.push_back(8'h30);
        for (int i = 0; i < 40; i++) body.push_back(8'h40 + 8'(i));
        send_frame(body, 8'h00);
        idle(4);
        expect_status("R11 overflow", 1'b0, 7'h0, 8'h0, 1'b0);
        @(negedge clk);
        out_ready = 1'b1;
        idle(10);
        chk(got_q.size() == 0, "R11 overflow nothing out", got_q.size(), 0);
        clear();
        send_frame('{8'h31, 8'h77}, 8'h00);
        idle(8);
        expect_status("R11 recovery", 1'b1, 7'h31, 8'h00, 1'b1);
        expect_out("R11 recovery output", '{8'h31, 8'h77});
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_addressed();
        t_cmd_only();
        t_bad_crc();
        t_outside();
        t_restart();
        t_bad_escape();
        t_short();
        t_backpressure();
        t_overflow();
        finish_up();
    end
endmodule